// File: doc/BRIEF.md
# Serial Control and Diagnosis Register for a Motor Bridge

This block is the serial configuration and fault-reporting port of a DC motor bridge controller. A host talks to it over a four-wire SPI link: serial clock, active-low select, data in and data out. Each frame is full duplex. The host shifts in a control byte, least significant bit first, and the block shifts out a diagnosis byte over the same clocks. When the select line is released after a whole number of bytes, the last byte received is latched into parallel fields. These fields set the chopper current-limit code, the chopper off-time code, the decay mode and the overvoltage-lockout enable, and can request a clear of the error flags.

Fault indications arrive as synchronous digital inputs: supply failure, a short to supply or across the load, a short to ground, an open load, and a two-bit temperature level. The block keeps a sticky copy of each fault. When a frame starts, it snapshots these flags into a fixed status layout and sends it back. The serial inputs are oversampled by the system clock through a short synchronizer, so the serial clock must be several times slower than the system clock. The single shift register passes data straight through, so several devices can share one select line in a chain.

Top module: `spi_diag_ctrl`

## Requirements
- R1: A frame starts when the synchronized select falls. The status byte is sent least significant bit first. Bit 0 is on `spi_sdo` before the first serial clock rising edge, and bit k is on `spi_sdo` when the serial clock falls for the (k+1)-th time.
- R2: `spi_sdi` is sampled on serial clock falling edges. `spi_sdo` changes only on serial clock rising edges or when a frame starts, and it stays constant from a falling edge to the next rising edge.
- R3: `spi_sdo_oe` is 1 while the select is low and 0 while it is high.
- R4: The committed control byte has this layout. Bit 7 requests an error clear. Bit 6 is `ctl_ov_lock_en`. Bit 5 is ignored. Bits 4:3 are `ctl_toff`. Bit 2 is `ctl_fast_decay` (1 = fast decay, 0 = slow decay). Bits 1:0 are `ctl_ilim`. The byte is applied only when the select rises.
- R5: The status byte has this layout. Bit 7 is supply failure. Bit 6 always reads 1. Bit 5 is a short to supply or across the load. Bit 4 is a short to ground. Bit 3 is an open load. Bits 2:1 are the temperature level. Bit 0 is the OR of bits 7 and 5 to 1. A 1 means error.
- R6: Each error flag is set in any clock cycle in which its fault input is 1, and it stays set after the input returns to 0.
- R7: A frame whose bit count is not a nonzero multiple of 8 is discarded, and all control outputs keep their previous values.
- R8: Committing a byte with bit 7 set produces a one-clock pulse on `ctl_stat_clr`. On the next clock, every error flag is reloaded from its current fault input, so a fault that is still active stays set.
- R9: A bit shifted in on `spi_sdi` appears on `spi_sdo` eight serial clocks later. A 16-bit frame commits the last 8 bits received.
- R10: After reset, all control outputs are 0, `ctl_stat_clr` and `spi_sdo_oe` are 0, and the first status byte reads 0x40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_csn | input | 1 | Active-low frame select |
| spi_sdi | input | 1 | Serial data from the host |
| spi_sdo | output | 1 | Serial data to the host |
| spi_sdo_oe | output | 1 | Output enable for an external tri-state `spi_sdo` driver |
| flt_supply | input | 1 | Supply failure indication |
| flt_short_vs | input | 1 | Short to supply or across the load |
| flt_short_gnd | input | 1 | Short to ground |
| flt_open | input | 1 | Open load |
| flt_temp | input | 2 | Temperature level (00 below prewarning, 01 prewarning) |
| ctl_ilim | output | 2 | Chopper current-limit code |
| ctl_fast_decay | output | 1 | 1 selects fast decay, 0 selects slow decay |
| ctl_toff | output | 2 | Chopper off-time code |
| ctl_ov_lock_en | output | 1 | Overvoltage-lockout enable |
| ctl_stat_clr | output | 1 | One-clock pulse when an error clear is committed |

## Verification
Some internal faults show up within one frame at the serial output. A wrong sticky flag, a lost clear or a shifted status layout each corrupt the next status byte the host reads. A shift register that is off by one bit corrupts the chain pass-through eight clocks later. A bad bit counter shows up a few system clocks after the select rises: a short frame changes the control fields, a whole frame leaves them unchanged, or the clear pulse is missing. The bench mixes random fault patterns, control bytes and frame lengths with directed frames. These cover reset, prewarning, a fault held through a clear, short frames and two-byte chains.

// File: rtl/spi_diag_pkg.sv
package spi_diag_pkg;

    localparam int FRAME_BITS = 8;
    localparam int CNT_W      = $clog2(FRAME_BITS);

    // Control byte; member order fixes the bit positions (R4)
    typedef struct packed {
        logic       stat_clr;    // bit 7
        logic       ov_lock;     // bit 6
        logic       spare;       // bit 5, ignored
        logic [1:0] toff;        // bits 4:3
        logic       fast_decay;  // bit 2
        logic [1:0] ilim;        // bits 1:0
    } ctrl_word_t;

    // Sticky fault set, one flag per reported condition
    typedef struct packed {
        logic       supply;
        logic       short_vs;
        logic       short_gnd;
        logic       open_load;
        logic [1:0] temp;
    } fault_set_t;

    localparam int FAULT_W = $bits(fault_set_t);

    // Status byte layout (R5)
    function automatic logic [FRAME_BITS-1:0] build_status(input fault_set_t f);
        return {f.supply, 1'b1, f.short_vs, f.short_gnd, f.open_load,
                f.temp, |f};
    endfunction

endpackage

// File: rtl/spi_diag_sync.sv
module spi_diag_sync #(
    parameter int          STAGES  = 2,
    parameter int          LINES   = 3,
    parameter logic [LINES-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] din,
    output logic [LINES-1:0] dout
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] pipe;
        always_ff @(posedge clk) begin
            if (rst) begin
                pipe <= {STAGES{RST_VAL[g]}};
            end else begin
                pipe <= {pipe[STAGES-2:0], din[g]};
            end
        end
        assign dout[g] = pipe[STAGES-1];
    end
endmodule

// File: rtl/spi_diag_shifter.sv
module spi_diag_shifter
    import spi_diag_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sclk_lvl,
    input  logic                  csn_lvl,
    input  logic                  sdi_lvl,
    input  logic [FRAME_BITS-1:0] load_word,
    output logic                  sdo,
    output logic                  sdo_oe,
    output logic [FRAME_BITS-1:0] word,
    output logic                  frame_ok
);
    logic                  sclk_d, csn_d;
    logic                  sclk_rise, sclk_fall, csn_fall, csn_rise;
    logic [FRAME_BITS-1:0] sr;
    logic [CNT_W-1:0]      cnt;
    logic                  full;

    assign sclk_rise = sclk_lvl & ~sclk_d;
    assign sclk_fall = ~sclk_lvl & sclk_d;
    assign csn_fall  = ~csn_lvl & csn_d;
    assign csn_rise  = csn_lvl & ~csn_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d   <= 1'b0;
            csn_d    <= 1'b1;
            sr       <= '0;
            cnt      <= '0;
            full     <= 1'b0;
            sdo      <= 1'b0;
            sdo_oe   <= 1'b0;
            frame_ok <= 1'b0;
        end else begin
            sclk_d   <= sclk_lvl;
            csn_d    <= csn_lvl;
            frame_ok <= 1'b0;
            if (csn_fall) begin
                // snapshot status so bit 0 leads the first edge (R1)
                sr     <= load_word;
                sdo    <= load_word[0];
                cnt    <= '0;
                full   <= 1'b0;
                sdo_oe <= 1'b1;
            end else if (!csn_lvl) begin
                if (sclk_fall) begin
                    // LSB-first capture on falling edge (R2, R9)
                    sr <= {sdi_lvl, sr[FRAME_BITS-1:1]};
                    if (cnt == CNT_W'(FRAME_BITS - 1)) begin
                        cnt  <= '0;
                        full <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                if (sclk_rise) begin
                    sdo <= sr[0];
                end
            end
            if (csn_rise) begin
                sdo_oe   <= 1'b0;                      // R3
                frame_ok <= full && (cnt == '0);       // R7
            end
        end
    end

    assign word = sr;
endmodule

// File: rtl/spi_diag_errlog.sv
module spi_diag_errlog
    import spi_diag_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  fault_set_t            fault_now,
    input  logic                  clear,
    output fault_set_t            err_q,
    output logic [FRAME_BITS-1:0] status_word
);
    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= '0;
        end else if (clear) begin
            err_q <= fault_now;                  // R8 recapture
        end else begin
            err_q <= err_q | fault_now;          // R6 sticky
        end
    end

    assign status_word = build_status(err_q);
endmodule

// File: rtl/spi_diag_ctrl.sv
module spi_diag_ctrl
    import spi_diag_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       spi_sclk,
    input  logic       spi_csn,
    input  logic       spi_sdi,
    output logic       spi_sdo,
    output logic       spi_sdo_oe,
    input  logic       flt_supply,
    input  logic       flt_short_vs,
    input  logic       flt_short_gnd,
    input  logic       flt_open,
    input  logic [1:0] flt_temp,
    output logic [1:0] ctl_ilim,
    output logic       ctl_fast_decay,
    output logic [1:0] ctl_toff,
    output logic       ctl_ov_lock_en,
    output logic       ctl_stat_clr
);
    logic [2:0]            lines;
    logic [FRAME_BITS-1:0] shift_word;
    logic [FRAME_BITS-1:0] status_word;
    logic                  frame_ok;
    ctrl_word_t            ctrl_q;
    logic                  stat_clr_q;
    fault_set_t            fault_now;
    fault_set_t            err_q;

    spi_diag_sync #(
        .STAGES (SYNC_STAGES),
        .LINES  (3),
        .RST_VAL(3'b010)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .din ({spi_sdi, spi_csn, spi_sclk}),
        .dout(lines)
    );

    spi_diag_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .sclk_lvl (lines[0]),
        .csn_lvl  (lines[1]),
        .sdi_lvl  (lines[2]),
        .load_word(status_word),
        .sdo      (spi_sdo),
        .sdo_oe   (spi_sdo_oe),
        .word     (shift_word),
        .frame_ok (frame_ok)
    );

    assign fault_now = '{supply:    flt_supply,
                         short_vs:  flt_short_vs,
                         short_gnd: flt_short_gnd,
                         open_load: flt_open,
                         temp:      flt_temp};

    spi_diag_errlog u_err (
        .clk        (clk),
        .rst        (rst),
        .fault_now  (fault_now),
        .clear      (stat_clr_q),
        .err_q      (err_q),
        .status_word(status_word)
    );

    // Commit on select release (R4, R7, R8, R10)
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            stat_clr_q <= 1'b0;
        end else begin
            stat_clr_q <= 1'b0;
            if (frame_ok) begin
                ctrl_q     <= ctrl_word_t'(shift_word);
                stat_clr_q <= shift_word[FRAME_BITS-1];
            end
        end
    end

    assign ctl_ilim       = ctrl_q.ilim;
    assign ctl_fast_decay = ctrl_q.fast_decay;
    assign ctl_toff       = ctrl_q.toff;
    assign ctl_ov_lock_en = ctrl_q.ov_lock;
    assign ctl_stat_clr   = stat_clr_q;
endmodule

// File: rtl/spi_diag_ctrl_chk.sv
module spi_diag_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       frame_ok,
    input logic [7:0] ctrl_q,
    input logic [7:0] shift_word,
    input logic       stat_clr,
    input logic [5:0] err_q,
    input logic       sdo,
    input logic       sdo_oe
);
    // R7: control only changes after an accepted frame
    assert_ctrl_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !frame_ok |=> $stable(ctrl_q));

    // R4: accepted frame is applied on the next clock
    assert_ctrl_apply_R4: assert property (@(posedge clk) disable iff (rst)
        frame_ok |=> (ctrl_q == $past(shift_word)));

    // R8: clear pulse exactly when committed byte has bit 7 set
    assert_clr_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        frame_ok |=> (stat_clr == ctrl_q[7]));

    // R6: without a clear, no set flag drops
    assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        !stat_clr |=> ((err_q & $past(err_q)) == $past(err_q)));

    // R1: first bit out is the summary flag of the snapshot
    assert_first_bit_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(sdo_oe) |-> (sdo == $past(|err_q)));
endmodule

bind spi_diag_ctrl spi_diag_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .frame_ok  (frame_ok),
    .ctrl_q    (ctrl_q),
    .shift_word(shift_word),
    .stat_clr  (stat_clr_q),
    .err_q     (err_q),
    .sdo       (spi_sdo),
    .sdo_oe    (spi_sdo_oe)
);

// File: tb/spi_diag_ctrl_tb.sv
`timescale 1ns/1ps
module spi_diag_ctrl_tb;
    localparam int H = 6;   // system clocks per serial half period

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sclk = 1'b0, csn = 1'b1, sdi = 1'b0;
    logic       sdo, sdo_oe;
    logic [5:0] fvec = '0;  // {supply, short_vs, short_gnd, open, temp[1:0]}
    logic [1:0] ilim, toff;
    logic       fast, ovl, sclr;

    int tests = 0, fails = 0, clr_cnt = 0;
    bit done = 0;
    logic [5:0] m_err;
    logic [7:0] m_ctrl;

    always #2 clk = ~clk;

    spi_diag_ctrl u_dut (
        .clk(clk), .rst(rst),
        .spi_sclk(sclk), .spi_csn(csn), .spi_sdi(sdi),
        .spi_sdo(sdo), .spi_sdo_oe(sdo_oe),
        .flt_supply(fvec[5]), .flt_short_vs(fvec[4]), .flt_short_gnd(fvec[3]),
        .flt_open(fvec[2]), .flt_temp(fvec[1:0]),
        .ctl_ilim(ilim), .ctl_fast_decay(fast), .ctl_toff(toff),
        .ctl_ov_lock_en(ovl), .ctl_stat_clr(sclr)
    );

    always @(posedge clk) if (!rst && sclr) clr_cnt++;

    function automatic logic [7:0] exp_status(input logic [5:0] e);
        return {e[5], 1'b1, e[4], e[3], e[2], e[1:0], |e};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_ctrl(input string req);
        logic [7:0] got;
        got = {1'b0, ovl, 1'b0, toff, fast, ilim};
        check(got == (m_ctrl & 8'h5f), req, "control fields", got, m_ctrl & 8'h5f);
    endtask

    task automatic pulse_fault(input logic [5:0] f);
        @(negedge clk) fvec = f;
        repeat (3) @(negedge clk);
        fvec = '0;
        m_err = m_err | f;
        repeat (2) @(negedge clk);
    endtask

    // One frame of n bits; checks serial data, enable and commit effects
    task automatic frame(input logic [15:0] tx, input int n);
        logic [15:0] rx, exp, mask;
        logic [7:0]  st;
        bit          hold_ok;
        int          clr0;
        logic [7:0]  prev_ctrl;
        hold_ok   = 1;
        clr0      = clr_cnt;
        prev_ctrl = m_ctrl;
        st        = exp_status(m_err);
        rx        = '0;
        @(negedge clk) csn = 1'b0;
        repeat (H) @(negedge clk);
        check(sdo_oe == 1'b1, "R3", "oe while selected", sdo_oe, 1);
        for (int i = 0; i < n; i++) begin
            sclk = 1'b1; sdi = tx[i];
            repeat (H) @(negedge clk);
            rx[i] = sdo;
            sclk = 1'b0;
            repeat (H) @(negedge clk);
            if (sdo !== rx[i]) hold_ok = 0;
        end
        check(hold_ok, "R2", "sdo stable after falling edge", 0, 0);
        csn = 1'b1;
        repeat (H) @(negedge clk);
        check(sdo_oe == 1'b0, "R3", "oe after release", sdo_oe, 0);
        mask = (n >= 16) ? 16'hffff : ((16'h1 << n) - 16'h1);
        exp  = {tx[7:0], st};
        if (n > 8)
            check((rx & mask) == (exp & mask), "R9", "chained data out", rx & mask, exp & mask);
        else
            check((rx & mask) == (exp & mask), "R1", "status bits out", rx & mask, exp & mask);
        if (n > 0 && n % 8 == 0) begin
            m_ctrl = tx[n-8 +: 8];
            check_ctrl("R4");
            if (m_ctrl[7]) m_err = fvec;
            check(clr_cnt - clr0 == (m_ctrl[7] ? 1 : 0), "R8", "clear pulses",
                  clr_cnt - clr0, m_ctrl[7] ? 1 : 0);
        end else begin
            check(m_ctrl == prev_ctrl, "R7", "model held", m_ctrl, prev_ctrl);
            check_ctrl("R7");
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_err  = '0;
        m_ctrl = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        // R10 reset state
        check({ilim, toff, fast, ovl, sclr} == 7'd0, "R10", "reset controls",
              {ilim, toff, fast, ovl, sclr}, 0);
        check(sdo_oe == 1'b0, "R10", "reset oe", sdo_oe, 0);
        frame(16'h0000, 8);   // R10: status reads 0x40 after reset
        // R4 all field positions, bit 5 ignored
        frame(16'h007f, 8);
        frame(16'h0025, 8);
        // R6 sticky open load, then prewarning
        pulse_fault(6'b000100);
        frame(16'h0012, 8);
        frame(16'h0012, 8);
        pulse_fault(6'b000001);
        frame(16'h0003, 8);
        // R8 clear with nothing active
        frame(16'h0080, 8);
        frame(16'h0000, 8);
        // R8 clear while short to ground is held active
        @(negedge clk) fvec = 6'b001000; m_err = m_err | fvec;
        repeat (3) @(negedge clk);
        frame(16'h0081, 8);
        @(negedge clk) fvec = '0;
        frame(16'h0000, 8);
        frame(16'h0080, 8);
        // R7 short frames discarded
        frame(16'h00ff, 5);
        frame(16'h0055, 1);
        frame(16'h5555, 12);
        // R9 chain of two bytes
        frame(16'h9a3c, 16);
        // random mix
        for (int k = 0; k < 40; k++) begin
            logic [5:0]  f;
            logic [15:0] tx;
            int          sel, n;
            f   = ($urandom % 2) ? 6'($urandom) : 6'd0;
            tx  = 16'($urandom);
            sel = $urandom % 6;
            n   = (sel < 4) ? 8 : (sel == 4) ? 16 : 1 + ($urandom % 7);
            if (f != 0) pulse_fault(f);
            frame(tx, n);
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule